// File: doc/BRIEF.md
# Packet-command PIO read sequencer

This block is the device side of a packet-command read carried out in programmed I/O mode behind an eight-register task-file port. The host writes a byte-count limit into the two cylinder-style registers and issues the packet command. The device then raises a data request so the host can write a 12-byte command packet as six 16-bit words. It decodes a READ(10) packet and asks a block source for the data. It returns that data through the data register in bursts no longer than the host's limit, with an interrupt in front of every burst and a final completion interrupt.

Block data arrives on a valid/ready word stream. The sequencer takes a word only when `src_valid` and `src_ready` are both high. `src_data` must stay steady while `src_valid` is high and `src_ready` is low. `src_ready` drops whenever the single holding word is full and not being read, so a slow host stalls the source. A one-cycle `src_cmd_valid` pulse, carrying the decoded block address and block count, opens each stream.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x40 (ready only: bit 7 busy, bit 6 ready, bit 3 data request, bit 0 error) and `irq` is low.
- R2: Writing 0xA0 to address 7 while idle latches the limit from address 4 (low byte) and address 5 (high byte). The device first shows busy (0x80 set). It then shows 0x48 while it waits for six packet words written to address 0.
- R3: Packet word i carries packet byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Byte 0 is the opcode (0x28 for a read). Bytes 2 to 5 are the block address, most significant first. Bytes 7 and 8 are the block count, most significant first. A valid read with a non-zero count pulses `src_cmd_valid` with these values on `src_lba` and `src_blocks`.
- R4: Let L be the limit with bit 0 cleared, or 0xFFFE if that is zero. Each burst holds min(L/2, remaining words) words. Its length in bytes reads back from address 4 (low) and address 5 (high) from the burst interrupt onward.
- R5: `irq` rises at the start of every burst. During a burst, status reads 0x48 whenever a word is waiting, and busy is never shown together with data request.
- R6: After the last word is read, `irq` rises and status reads 0x40. A read with a block count of zero completes the same way with no data phase.
- R7: A status read clears a pending interrupt.
- R8: Data words appear on address 0 in stream order, one word consumed per read. `src_ready` is high only while a transfer is fetching data.
- R9: A command other than 0xA0, or a packet opcode other than 0x28, ends with status 0x41, error register (address 1) 0x04 and `irq` high. The error clears on the next accepted command.
- R10: A command write while the device is not idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tf_addr | input | 3 | Task-file register address |
| tf_wr | input | 1 | Register write strobe |
| tf_rd | input | 1 | Register read strobe (reads of address 0 and 7 have side effects) |
| tf_wdata | input | 16 | Write data (8-bit registers use bits 7:0) |
| tf_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request to the host |
| src_cmd_valid | output | 1 | One-cycle request to the block source |
| src_lba | output | 32 | First block of the request |
| src_blocks | output | 16 | Number of blocks requested |
| src_valid | input | 1 | Source word valid |
| src_ready | output | 1 | Sequencer accepts a source word |
| src_data | input | 16 | Source word |

## Verification
The bench builds the sequencer with blocks of 8 words (16 bytes) and the default six-word packet. With blocks this short, the full limit sweep becomes affordable. Limits of zero, one, one word, odd values, values just above a block and the maximum run against block counts from zero to five. This covers single-word bursts, exact-fit bursts, short final remainders and single-burst transfers, all with a source that stalls between words. Abort paths, interrupt clearing and a command written mid-burst are driven on the same small configuration.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_PKT, ST_DEC, ST_PREP, ST_DATA
  } seq_state_t;

  localparam logic [2:0] TF_DATA    = 3'd0;
  localparam logic [2:0] TF_ERRFEAT = 3'd1;
  localparam logic [2:0] TF_SCNT    = 3'd2;
  localparam logic [2:0] TF_LBAL    = 3'd3;
  localparam logic [2:0] TF_LBAM    = 3'd4;
  localparam logic [2:0] TF_LBAH    = 3'd5;
  localparam logic [2:0] TF_DEV     = 3'd6;
  localparam logic [2:0] TF_STATCMD = 3'd7;

  localparam int SB_BSY = 7;
  localparam int SB_DRQ = 3;

  localparam logic [7:0] OPC_PACKET = 8'hA0;
  localparam logic [7:0] OPC_READ10 = 8'h28;
  localparam logic [7:0] ERRB_ABRT  = 8'h04;
endpackage

// File: rtl/atapi_pkt_collect.sv
module atapi_pkt_collect #(
  parameter int PKT_WORDS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic        full,
  output logic [7:0]  opcode,
  output logic [31:0] lba,
  output logic [15:0] nblk
);
  localparam int CNT_W  = $clog2(PKT_WORDS + 1);
  localparam int FLAT_W = 16 * PKT_WORDS;

  logic [CNT_W-1:0]  cnt_q;
  logic [15:0]       words_q [PKT_WORDS];
  logic [FLAT_W-1:0] flat;

  assign full = (cnt_q == CNT_W'(PKT_WORDS));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear)            cnt_q <= '0;
    else if (wr_en && !full)   cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < PKT_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        words_q[i] <= '0;
      else if (wr_en && !full && cnt_q == CNT_W'(i))
        words_q[i] <= wdata;
    end
    assign flat[16*i +: 16] = words_q[i];
  end

  // byte k of the packet sits at flat[8k +: 8]
  assign opcode = flat[7:0];
  assign lba    = {flat[23:16], flat[31:24], flat[39:32], flat[47:40]};
  assign nblk   = {flat[63:56], flat[71:64]};
endmodule

// File: rtl/atapi_burst_plan.sv
module atapi_burst_plan #(
  parameter int TOT_W = 27,
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] lim,
  input  logic             load,
  input  logic [TOT_W-1:0] total,
  input  logic             start,
  input  logic             pop,
  output logic [LIM_W-2:0] burst_sz,
  output logic [LIM_W-2:0] burst_left,
  output logic             remain_zero
);
  logic [TOT_W-1:0] remain_q;
  logic [LIM_W-2:0] lim_words;

  // even limit in words; a zero even limit folds to the largest even value
  assign lim_words   = (lim[LIM_W-1:1] == '0) ? '1 : lim[LIM_W-1:1];
  assign burst_sz    = (remain_q < TOT_W'(lim_words)) ? remain_q[LIM_W-2:0] : lim_words;
  assign remain_zero = (remain_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q   <= '0;
      burst_left <= '0;
    end else begin
      if (load)
        remain_q <= total;
      else if (start)
        remain_q <= remain_q - TOT_W'(burst_sz);
      if (start)
        burst_left <= burst_sz;
      else if (pop)
        burst_left <= burst_left - 1'b1;
    end
  end
endmodule

// File: rtl/atapi_word_hold.sv
module atapi_word_hold #(
  parameter int W  = 16,
  parameter int CW = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] total,
  input  logic          src_valid,
  input  logic [W-1:0]  src_data,
  input  logic          pop,
  output logic          src_ready,
  output logic          hold_valid,
  output logic [W-1:0]  hold_data
);
  logic [CW-1:0] fetch_q;
  logic          take;

  assign src_ready = (fetch_q != '0) && (!hold_valid || pop);
  assign take      = src_valid && src_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_q    <= '0;
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else begin
      if (load)
        fetch_q <= total;
      else if (take)
        fetch_q <= fetch_q - 1'b1;
      if (take) begin
        hold_valid <= 1'b1;
        hold_data  <= src_data;
      end else if (pop) begin
        hold_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
  import atapi_seq_pkg::*;
#(
  parameter int BLOCK_WORDS = 1024,
  parameter int PKT_WORDS   = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  tf_addr,
  input  logic        tf_wr,
  input  logic        tf_rd,
  input  logic [15:0] tf_wdata,
  output logic [15:0] tf_rdata,
  output logic        irq,
  output logic        src_cmd_valid,
  output logic [31:0] src_lba,
  output logic [15:0] src_blocks,
  input  logic        src_valid,
  output logic        src_ready,
  input  logic [15:0] src_data
);
  localparam int LIM_W = 16;
  localparam int TOT_W = 16 + $clog2(BLOCK_WORDS) + 1;

  seq_state_t state_q, state_d;
  logic [7:0]  scnt_q, lbal_q, lbam_q, lbah_q, dev_q;
  logic [15:0] lim_q;
  logic        err_q, irq_q;

  logic        pkt_full;
  logic [7:0]  pkt_opc;
  logic [31:0] pkt_lba;
  logic [15:0] pkt_nblk;
  logic [TOT_W-1:0] total_words;

  logic [LIM_W-2:0] burst_sz, burst_left;
  logic             remain_zero;
  logic             hold_valid;
  logic [15:0]      hold_data;
  logic [7:0]       stat_byte;

  logic cmd_acc, cmd_pkt, pkt_wr, dec_bad, dec_zero, dec_go;
  logic abort_evt, start_burst, pop, burst_end, done_evt, rd_stat;
  logic irq_set, irq_clr, bsy, drq;

  assign cmd_acc     = tf_wr && tf_addr == TF_STATCMD && state_q == ST_IDLE;
  assign cmd_pkt     = cmd_acc && tf_wdata[7:0] == OPC_PACKET;
  assign pkt_wr      = tf_wr && tf_addr == TF_DATA && state_q == ST_PKT;
  assign dec_bad     = state_q == ST_DEC && pkt_opc != OPC_READ10;
  assign dec_zero    = state_q == ST_DEC && !dec_bad && pkt_nblk == '0;
  assign dec_go      = state_q == ST_DEC && !dec_bad && pkt_nblk != '0;
  assign abort_evt   = (cmd_acc && !cmd_pkt) || dec_bad;
  assign start_burst = state_q == ST_PREP && hold_valid;
  assign pop         = tf_rd && tf_addr == TF_DATA && state_q == ST_DATA && hold_valid;
  assign burst_end   = pop && burst_left == LIM_W'(1);
  assign done_evt    = burst_end && remain_zero;
  assign rd_stat     = tf_rd && tf_addr == TF_STATCMD;

  assign total_words = TOT_W'(pkt_nblk) * TOT_W'(BLOCK_WORDS);

  atapi_pkt_collect #(.PKT_WORDS(PKT_WORDS)) u_pkt (
    .clk(clk), .rst_n(rst_n), .clear(cmd_pkt), .wr_en(pkt_wr), .wdata(tf_wdata),
    .full(pkt_full), .opcode(pkt_opc), .lba(pkt_lba), .nblk(pkt_nblk)
  );

  atapi_burst_plan #(.TOT_W(TOT_W), .LIM_W(LIM_W)) u_plan (
    .clk(clk), .rst_n(rst_n), .lim(lim_q), .load(dec_go), .total(total_words),
    .start(start_burst), .pop(pop), .burst_sz(burst_sz), .burst_left(burst_left),
    .remain_zero(remain_zero)
  );

  atapi_word_hold #(.W(16), .CW(TOT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(dec_go), .total(total_words),
    .src_valid(src_valid), .src_data(src_data), .pop(pop),
    .src_ready(src_ready), .hold_valid(hold_valid), .hold_data(hold_data)
  );

  assign src_cmd_valid = dec_go;
  assign src_lba       = pkt_lba;
  assign src_blocks    = pkt_nblk;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (cmd_pkt) state_d = ST_CMD;
      ST_CMD:  state_d = ST_PKT;
      ST_PKT:  if (pkt_full) state_d = ST_DEC;
      ST_DEC:  state_d = dec_go ? ST_PREP : ST_IDLE;
      ST_PREP: if (hold_valid) state_d = ST_DATA;
      ST_DATA: if (burst_end) state_d = remain_zero ? ST_IDLE : ST_PREP;
      default: state_d = ST_IDLE;
    endcase
  end

  assign irq_set = abort_evt || start_burst || done_evt || dec_zero;
  assign irq_clr = rd_stat || cmd_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      if (abort_evt)    err_q <= 1'b1;
      else if (cmd_acc) err_q <= 1'b0;
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (cmd_pkt)      lim_q <= {lbah_q, lbam_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt_q <= '0;
      lbal_q <= '0;
      lbam_q <= '0;
      lbah_q <= '0;
      dev_q  <= '0;
    end else begin
      if (tf_wr) begin
        case (tf_addr)
          TF_SCNT: scnt_q <= tf_wdata[7:0];
          TF_LBAL: lbal_q <= tf_wdata[7:0];
          TF_LBAM: lbam_q <= tf_wdata[7:0];
          TF_LBAH: lbah_q <= tf_wdata[7:0];
          TF_DEV:  dev_q  <= tf_wdata[7:0];
          default: ;
        endcase
      end
      if (start_burst)
        {lbah_q, lbam_q} <= {burst_sz, 1'b0};
    end
  end

  assign bsy = state_q == ST_CMD || state_q == ST_DEC || state_q == ST_PREP;
  assign drq = state_q == ST_PKT || (state_q == ST_DATA && hold_valid);
  assign stat_byte = {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err_q};
  assign irq = irq_q;

  always_comb begin
    case (tf_addr)
      TF_DATA:    tf_rdata = (state_q == ST_DATA && hold_valid) ? hold_data : 16'h0000;
      TF_ERRFEAT: tf_rdata = {8'h00, err_q ? ERRB_ABRT : 8'h00};
      TF_SCNT:    tf_rdata = {8'h00, scnt_q};
      TF_LBAL:    tf_rdata = {8'h00, lbal_q};
      TF_LBAM:    tf_rdata = {8'h00, lbam_q};
      TF_LBAH:    tf_rdata = {8'h00, lbah_q};
      TF_DEV:     tf_rdata = {8'h00, dev_q};
      default:    tf_rdata = {8'h00, stat_byte};
    endcase
  end
endmodule

// File: rtl/atapi_pio_seq_chk.sv
module atapi_pio_seq_chk
  import atapi_seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input seq_state_t  st,
  input logic        irq,
  input logic        tf_rd,
  input logic        tf_wr,
  input logic [2:0]  tf_addr,
  input logic [7:0]  stat,
  input logic        err,
  input logic        src_ready,
  input logic [14:0] burst_left,
  input logic [15:0] lim
);
  AST_NO_BSY_WITH_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[SB_BSY] && stat[SB_DRQ])); // R5

  AST_IRQ_DROPS_ON_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_rd && tf_addr == TF_STATCMD && st == ST_DATA) |=> !irq); // R7

  AST_BURST_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) |-> (burst_left != '0 &&
                         (lim[15:1] == '0 || burst_left <= lim[15:1]))); // R4

  AST_ERR_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> st == ST_IDLE); // R9

  AST_SOURCE_ONLY_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (st == ST_PREP || st == ST_DATA)); // R8

  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_wr && tf_addr == TF_STATCMD && st == ST_DATA) |=> st != ST_CMD); // R10
endmodule

bind atapi_pio_seq atapi_pio_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(state_q), .irq(irq_q), .tf_rd(tf_rd), .tf_wr(tf_wr),
  .tf_addr(tf_addr), .stat(stat_byte), .err(err_q), .src_ready(src_ready),
  .burst_left(burst_left), .lim(lim_q)
);

// File: tb/tb_atapi_pio_seq.sv
module tb_atapi_pio_seq;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  tf_addr = '0;
  logic        tf_wr = 1'b0, tf_rd = 1'b0;
  logic [15:0] tf_wdata = '0;
  logic [15:0] tf_rdata;
  logic        irq, src_cmd_valid, src_ready;
  logic [31:0] src_lba;
  logic [15:0] src_blocks, src_data;
  logic        src_valid;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  atapi_pio_seq #(.BLOCK_WORDS(BW)) dut (
    .clk(clk), .rst_n(rst_n), .tf_addr(tf_addr), .tf_wr(tf_wr), .tf_rd(tf_rd),
    .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .irq(irq),
    .src_cmd_valid(src_cmd_valid), .src_lba(src_lba), .src_blocks(src_blocks),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data)
  );

  function automatic logic [15:0] ew(input int unsigned n);
    logic [31:0] t;
    t = (n * 32'h9E37) ^ 32'h5A5A;
    return t[15:0];
  endfunction

  // block source model with stalls between words
  int unsigned src_base = 0, src_idx = 0;
  int gap = 0;
  logic [31:0] req_lba = '0;
  logic [15:0] req_blk = '0;

  assign src_data = ew(src_base + src_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_base <= 0; src_idx <= 0; src_valid <= 1'b0; gap <= 0;
    end else if (src_cmd_valid) begin
      src_base <= src_lba * BW; src_idx <= 0;
      req_lba <= src_lba; req_blk <= src_blocks;
    end else if (src_valid && src_ready) begin
      src_idx <= src_idx + 1; src_valid <= 1'b0; gap <= int'(src_idx % 3);
    end else if (!src_valid) begin
      if (gap == 0) src_valid <= 1'b1;
      else gap <= gap - 1;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tf_write(input logic [2:0] a, input logic [15:0] d);
    tf_addr = a; tf_wdata = d; tf_wr = 1'b1;
    @(negedge clk);
    tf_wr = 1'b0;
  endtask

  task automatic tf_read(input logic [2:0] a, output logic [15:0] d);
    tf_addr = a; tf_rd = 1'b1;
    #1 d = tf_rdata;
    @(negedge clk);
    tf_rd = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 400) begin @(negedge clk); n++; end
    chk({31'b0, irq}, 32'd1, tag);
  endtask

  task automatic status_not_busy(output logic [15:0] s);
    int n = 0;
    tf_read(3'd7, s);
    while (s[7] && n < 200) begin tf_read(3'd7, s); n++; end
  endtask

  task automatic xfer(input logic [15:0] lim, input logic [31:0] lba,
                      input logic [15:0] nblk, input logic [7:0] opc, input bit inject);
    logic [15:0] s, d, lo, hi;
    logic [7:0] pb [12];
    int unsigned eff, wpb, remaining, bw, n;
    tf_write(3'd4, {8'h00, lim[7:0]});
    tf_write(3'd5, {8'h00, lim[15:8]});
    tf_write(3'd7, 16'h00A0);
    status_not_busy(s);
    chk({16'h0, s}, 32'h48, "R2 packet request status");
    for (int i = 0; i < 12; i++) pb[i] = 8'h00;
    pb[0] = opc; pb[2] = lba[31:24]; pb[3] = lba[23:16]; pb[4] = lba[15:8];
    pb[5] = lba[7:0]; pb[7] = nblk[15:8]; pb[8] = nblk[7:0];
    for (int i = 0; i < 6; i++) tf_write(3'd0, {pb[2*i+1], pb[2*i]});
    if (opc != 8'h28) begin
      wait_irq("R9 abort interrupt");
      tf_read(3'd7, s);
      chk({16'h0, s}, 32'h41, "R9 abort status");
      chk({31'b0, irq}, 32'd0, "R7 irq cleared");
      tf_read(3'd1, d);
      chk({16'h0, d}, 32'h04, "R9 abort error code");
      return;
    end
    eff = ((lim & 16'hFFFE) == 0) ? 32'hFFFE : (lim & 16'hFFFE);
    wpb = eff / 2;
    remaining = nblk * BW;
    n = 0;
    while (remaining > 0) begin
      bw = (remaining < wpb) ? remaining : wpb;
      wait_irq("R5 burst interrupt");
      tf_read(3'd7, s);
      chk({16'h0, s}, 32'h48, "R5 burst status");
      chk({31'b0, irq}, 32'd0, "R7 irq cleared");
      tf_read(3'd4, lo);
      tf_read(3'd5, hi);
      chk({16'h0, hi[7:0], lo[7:0]}, bw * 2, "R4 burst byte count");
      for (int j = 0; j < int'(bw); j++) begin
        int k = 0;
        tf_read(3'd7, s);
        while (!s[3] && k < 50) begin tf_read(3'd7, s); k++; end
        tf_read(3'd0, d);
        chk({16'h0, d}, {16'h0, ew(lba * BW + n)}, "R8 data word");
        n++;
        if (inject && n == 1) tf_write(3'd7, 16'h00A0); // R10 ignored mid-burst
      end
      remaining -= bw;
    end
    if (nblk != 0) begin
      chk(req_lba, lba, "R3 source block address");
      chk({16'h0, req_blk}, {16'h0, nblk}, "R3 source block count");
    end
    wait_irq("R6 completion interrupt");
    tf_read(3'd7, s);
    chk({16'h0, s}, 32'h40, "R6 completion status");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] s, d;
    logic [15:0] lims [11];
    logic [15:0] cnts [5];
    lims = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0006,
             16'h000A, 16'h0010, 16'h0011, 16'h0028, 16'hFFFF};
    cnts = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd5};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tf_read(3'd7, s);
    chk({16'h0, s}, 32'h40, "R1 reset status");
    chk({31'b0, irq}, 32'd0, "R1 reset irq");

    // R9: unsupported command
    tf_write(3'd7, 16'h00EC);
    @(negedge clk);
    chk({31'b0, irq}, 32'd1, "R9 bad command irq");
    tf_read(3'd7, s);
    chk({16'h0, s}, 32'h41, "R9 bad command status");
    chk({31'b0, irq}, 32'd0, "R7 irq cleared by status read");
    tf_read(3'd1, d);
    chk({16'h0, d}, 32'h04, "R9 bad command error code");

    for (int ci = 0; ci < 5; ci++)
      for (int li = 0; li < 11; li++)
        xfer(lims[li], 32'(100 * ci + 7 * li + 3), cnts[ci], 8'h28,
             (lims[li] == 16'h0006 && cnts[ci] == 16'd3));

    // R9: bad packet opcodes, then recovery
    xfer(16'h0010, 32'd9, 16'd1, 8'h12, 1'b0);
    xfer(16'h0010, 32'd9, 16'd1, 8'h00, 1'b0);
    xfer(16'h0020, 32'h0102_0304, 16'd2, 8'h28, 1'b0);
    tf_read(3'd1, d);
    chk({16'h0, d}, 32'h00, "R9 error cleared by new command");
    finish_run();
  end
endmodule